// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block takes bytes from a processor-side write strobe and sends them as asynchronous serial characters on a single output line. It has two storage stages. A holding register receives the byte from the processor. A frame shifter serializes the byte. Because of this split, software can queue the next byte while the current character is still going out. When the holding register is empty, a ready flag tells software that it may write again. A second flag reports that the whole transmit path is idle.

Bit timing comes from a transmit tick enable, one pulse per transmit clock period. A rate select divides this tick by 1, 16 or 64 to form one bit period. Each character has the following parts, in order:
- a low start bit;
- 5 to 8 data bits, least significant bit first;
- an optional even or odd parity bit;
- one or two high stop bits.

A single enable input gates the start of new characters. A character that is already being sent always runs to its end.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1 and tx_empty is 1.
- R2: A clock edge with wr_en high stores wr_data in the holding register. After that edge tx_ready is 0, and it stays 0 until the byte moves into the shifter.
- R3: A byte moves from the holding register to the shifter on an edge where tx_enable is 1 and either no character is in progress or the last stop bit is ending. After that edge tx_empty is 0. tx_empty returns to 1 only when a character ends and no byte moves in.
- R4: A character starts with one 0 bit. Then come 5+len_sel data bits, least significant first. len_sel values 0,1,2,3 select 5,6,7,8 bits. Unused upper bits of wr_data are not sent.
- R5: When par_en is 1, one parity bit follows the data bits. With par_odd=0 the number of ones in the data bits plus the parity bit is even; with par_odd=1 it is odd. When par_en is 0, no parity bit is sent.
- R6: The character ends with one 1 stop bit when two_stop is 0, and two 1 stop bits when two_stop is 1.
- R7: Each bit lasts 1, 16 or 64 tick_en pulses for rate_sel 0, 1 or 2. rate_sel 3 acts as 64.
- R8: While no character is in progress, txd is 1.
- R9: A write while the holding register is full replaces the buffered byte. The character in progress goes out unchanged.
- R10: If a write falls on the same edge as a transfer, the old buffered byte goes to the shifter, the new byte stays buffered, and tx_ready stays 0.
- R11: While tx_enable is 0, no byte moves into the shifter. tx_ready stays 0 if a byte is buffered, and an idle line stays at 1.
- R12: If a byte is waiting when the last stop bit ends, its start bit follows on the next bit period, with no idle time between the characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| tx_enable | input | 1 | Allows new characters to start |
| tick_en | input | 1 | Transmit clock enable pulse |
| rate_sel | input | 2 | Ticks per bit: 0=1, 1=16, 2/3=64 |
| len_sel | input | 2 | Data bits: 0..3 give 5..8 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial output, idles at 1 |
| tx_ready | output | 1 | Holding register is empty |
| tx_empty | output | 1 | No character in progress |

## Verification
A processor write and a holding-to-shifter transfer can fall on the same clock edge. The bench provokes this on purpose. It first holds a buffered byte with tx_enable low. It then raises tx_enable in the same cycle as a second write. The outcome is judged by tx_ready staying low after that edge, and by the decoded line carrying the first byte and then the second with no gap between them. Overwrites during a character, disabled starts and the three bit periods are also decoded from txd and compared against a queue of expected bytes.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X16 = 2'd1,
    RATE_X64 = 2'd2,
    RATE_XHI = 2'd3
  } rate_e;

  // Ticks per bit for a rate code; the codes above RATE_X16 use the high ratio.
  function automatic int ticks_per_bit(input rate_e r, input int mid, input int hi);
    case (r)
      RATE_X1:  return 1;
      RATE_X16: return mid;
      default:  return hi;
    endcase
  endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_d;
  logic [DATA_W-1:0] data_d;

  // A write always wins: the buffer stays full with the new byte.
  always_comb begin
    full_d = full;
    data_d = data;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end else if (take) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
  import ser_tx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  localparam int CNT_W  = $clog2(DIV_HI)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick_en,
  input  logic [1:0] rate_sel,
  output logic       bit_end
);

  logic [CNT_W-1:0] cnt, cnt_d, last_cnt;

  always_comb begin
    last_cnt = CNT_W'(ticks_per_bit(rate_e'(rate_sel), DIV_MID, DIV_HI) - 1);
    bit_end  = tick_en && (cnt == last_cnt);
    cnt_d    = cnt;
    if (restart)      cnt_d = '0;
    else if (bit_end) cnt_d = '0;
    else if (tick_en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int LSEL_W  = $clog2(DATA_W - MIN_LEN + 1),
  localparam int FRAME_W = DATA_W + 4,
  localparam int LEFT_W  = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [LSEL_W-1:0] len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              bit_end,
  output logic              busy,
  output logic              last_bit,
  output logic              sdo
);

  logic [FRAME_W-1:0] sr, sr_d, frame;
  logic [LEFT_W-1:0]  left, left_d, frame_len;
  logic               busy_d, par;
  int                 nlen;

  // Assemble start, data, parity and stop bits, LSB first on the line.
  always_comb begin
    nlen  = MIN_LEN + int'(len_sel);
    frame = '1;
    frame[0] = 1'b0;
    par = par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nlen) begin
        frame[1+i] = load_data[i];
        par        = par ^ load_data[i];
      end
    end
    for (int j = 1 + MIN_LEN; j <= DATA_W; j++) begin
      if (par_en && j == 1 + nlen) frame[j] = par;
    end
    frame[1+DATA_W] = par_en && (nlen == DATA_W) ? par : 1'b1;
    frame_len = LEFT_W'(2 + nlen + int'(par_en) + int'(two_stop));
  end

  always_comb begin
    last_bit = busy && bit_end && (left == LEFT_W'(1));
    sr_d     = sr;
    left_d   = left;
    busy_d   = busy;
    if (load) begin
      sr_d   = frame;
      left_d = frame_len;
      busy_d = 1'b1;
    end else if (busy && bit_end) begin
      sr_d   = {1'b1, sr[FRAME_W-1:1]};
      left_d = left - 1'b1;
      busy_d = !last_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else begin
      sr   <= sr_d;
      left <= left_d;
      busy <= busy_d;
    end
  end

  assign sdo = busy ? sr[0] : 1'b1;

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tx_enable,
  input  logic       tick_en,
  input  logic [1:0] rate_sel,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);

  localparam int DATA_W  = 8;
  localparam int MIN_LEN = 5;
  localparam int DIV_MID = 16;
  localparam int DIV_HI  = 64;
  localparam int SYNC_N  = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;
  logic              hold_full, busy, last_bit, bit_end, take;
  logic [DATA_W-1:0] hold_data;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  assign take = hold_full && tx_enable && (!busy || last_bit);

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(hold_full), .data(hold_data)
  );

  tx_bit_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .restart(take), .tick_en(tick_en),
    .rate_sel(rate_sel), .bit_end(bit_end)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(take), .load_data(hold_data),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .bit_end(bit_end), .busy(busy), .last_bit(last_bit), .sdo(txd)
  );

  assign tx_ready = !hold_full;
  assign tx_empty = !busy;

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tx_enable,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd); // R8

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tx_ready); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> !txd); // R4

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !tx_enable) |=> tx_empty); // R11

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_enable) |=> !tx_ready); // R11

  AST_COLLIDE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && tx_enable && tx_empty && wr_en) |=> (!tx_ready && !tx_empty)); // R10

endmodule

bind ser_tx_dbuf ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tx_enable(tx_enable),
  .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
);

// File: tb/tb_ser_tx_dbuf.sv
`timescale 1ns/1ps
module tb_ser_tx_dbuf;

  logic clk, rst_n, wr_en, tx_enable, tick_en, par_en, par_odd, two_stop;
  logic [7:0] wr_data;
  logic [1:0] rate_sel, len_sel;
  logic txd, tx_ready, tx_empty;

  int n_chk, n_fail, cyc, gap, tick_ph;
  bit done, b2b_mode, have_prev;
  int last_start;
  logic [7:0] exp_q[$];

  ser_tx_dbuf dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_cyc();
    int t;
    t = (rate_sel == 2'd0) ? 1 : (rate_sel == 2'd1) ? 16 : 64;
    return t * gap;
  endfunction

  // tick generator
  initial begin
    tick_en = 1'b0; tick_ph = 0;
    forever begin
      @(negedge clk);
      tick_ph = (tick_ph + 1 >= gap) ? 0 : tick_ph + 1;
      tick_en = (tick_ph == 0);
    end
  end

  task automatic wr(input logic [7:0] b, input bit expect_it);
    wr_en = 1'b1; wr_data = b;
    if (expect_it) exp_q.push_back(b & 8'((1 << (5 + int'(len_sel))) - 1));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k;
    k = 0;
    while ((exp_q.size() != 0 || !tx_empty) && k < 20000) begin
      @(negedge clk); k++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(tx_empty && txd, "R3/R8 idle after drain", {tx_empty, txd}, 3);
  endtask

  // monitor: decode frames from txd and compare with the scoreboard
  initial begin
    logic prev, s, p;
    logic [7:0] got, e;
    int n, bc;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (done) break;
      if (prev && !txd) begin
        if (b2b_mode && have_prev)
          chk(cyc - last_start == 10, "R12 back-to-back spacing", cyc - last_start, 10);
        last_start = cyc; have_prev = 1'b1;
        bc = bit_cyc();
        n = 5 + int'(len_sel);
        repeat (bc / 2) @(negedge clk);
        chk(txd == 1'b0, "R4 start bit", txd, 0);
        got = '0;
        for (int i = 0; i < n; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = txd;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected frame", got, 0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
          chk(got == e, "R4/R9 data bits", got, e);
        end
        if (par_en) begin
          repeat (bc) @(negedge clk);
          p = (^e) ^ par_odd;
          chk(txd == p, "R5 parity bit", txd, p);
        end
        for (int k = 0; k < (two_stop ? 2 : 1); k++) begin
          repeat (bc) @(negedge clk);
          s = txd;
          chk(s == 1'b1, "R6 stop bit", s, 1);
        end
        prev = 1'b1;
      end else begin
        prev = txd;
      end
    end
  end

  task automatic measure_start(input int exp_len, input string req);
    int len, k;
    wr(8'hFF, 1'b1);
    k = 0;
    while (txd && k < 1000) begin @(negedge clk); k++; end
    len = 0;
    while (!txd && len < 1000) begin @(negedge clk); len++; end
    chk(len == exp_len, req, len, exp_len);
    wait_idle(req);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; done = 0; gap = 1;
    b2b_mode = 0; have_prev = 0; last_start = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_enable = 1'b1;
    rate_sel = 2'd0; len_sel = 2'd3; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd && tx_ready && tx_empty, "R1 reset state", {txd, tx_ready, tx_empty}, 7);

    // R2/R3: write, transfer timing
    wr(8'hA5, 1'b1);
    chk(!tx_ready && tx_empty, "R2 buffered after write", {tx_ready, tx_empty}, 1);
    @(negedge clk);
    chk(tx_ready && !tx_empty && !txd, "R3 transfer starts frame",
        {tx_ready, tx_empty, txd}, 4);
    wait_idle("R3 8N1 x1");

    // R11 then R10 collision, with R12 spacing
    tx_enable = 1'b0;
    wr(8'h3C, 1'b1);
    repeat (20) @(negedge clk);
    chk(!tx_ready && tx_empty && txd, "R11 disabled holds byte",
        {tx_ready, tx_empty, txd}, 3);
    b2b_mode = 1; have_prev = 0;
    tx_enable = 1'b1;
    wr(8'h5A, 1'b1);
    chk(!tx_ready && !tx_empty, "R10 write meets transfer", {tx_ready, tx_empty}, 0);
    wait_idle("R10/R12 collision pair");
    b2b_mode = 0;

    // R9 overwrite, 7 bits even parity two stops, x16 with sparse ticks
    gap = 2; rate_sel = 2'd1; len_sel = 2'd2; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h11, 1'b1);
    repeat (3) @(negedge clk);
    wr(8'h22, 1'b0);
    repeat (5) @(negedge clk);
    wr(8'hB3, 1'b1);
    chk(!tx_ready, "R9 still full after overwrite", tx_ready, 0);
    wait_idle("R9 overwrite");

    // R5/R7: 5 bits odd parity at x64
    gap = 1; rate_sel = 2'd2; len_sel = 2'd0; par_odd = 1'b1; two_stop = 1'b0;
    repeat (4) @(negedge clk);
    wr(8'h0E, 1'b1);
    wait_idle("R5 odd 5-bit");
    wr(8'hF3, 1'b1);
    wait_idle("R4 upper bits masked");

    // R6/R5: 6 bits even parity x1, a run of patterns
    rate_sel = 2'd0; len_sel = 2'd1; par_odd = 1'b0; two_stop = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h00, 1'b1); wr(8'h3F, 1'b1);
    wait_idle("R5/R6 6-bit run");

    // R7 bit period
    par_en = 1'b0; len_sel = 2'd3; two_stop = 1'b0;
    rate_sel = 2'd0; measure_start(1, "R7 x1 bit length");
    rate_sel = 2'd1; measure_start(16, "R7 x16 bit length");
    rate_sel = 2'd2; measure_start(64, "R7 x64 bit length");
    rate_sel = 2'd3; measure_start(64, "R7 code3 bit length");

    done = 1;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule